// File: doc/BRIEF.md
# SD Host Single-Address DMA Transfer Engine

This block moves block-structured data between an SD card data buffer and system memory using plain single-address DMA. Software programs a start address, a block size together with a boundary code, a block count, and the DMA select field of the host control register. It then writes the transfer mode word, and that write starts the engine. The engine streams 32-bit words through a word-wide memory master port. In the read-from-card direction, words come from the card buffer input stream. In the write-to-card direction, words go out on the card buffer output stream.

Whenever the running address lands on a multiple of the programmed boundary size while words still remain, the engine halts and raises a boundary event. The engine continues only after software writes the system address register again, and it continues from the new address. When the last word has been moved, the engine raises a completion event. Both events pass through a status-enable mask into a sticky status register, which software clears by writing 1s. An interrupt line combines the recorded bits with a separate signal-enable mask.

Top module: `sdma_engine`

## Requirements
- R1: After reset, `int_status` is 0, `irq` is 0, `mem_valid` is 0 and `buf_out_valid` is 0.
- R2: A register write uses `reg_sel` codes 0 = system address, 1 = block config, 2 = block count, 3 = transfer mode, 4 = host control, 5 = status, 6 = status enable and 7 = signal enable. A transfer-mode write with bit 0 (DMA enable) set starts a transfer only when host control bits [4:3] are 00. The transfer starts at the programmed address with bits [1:0] forced to 0, and each accepted word (`mem_valid` and `mem_ready`) advances `mem_addr` by 4. If bits [4:3] are nonzero, or bit 0 of the mode word is 0, nothing moves.
- R3: Block config bits [11:2] give the words per block. The number of blocks is the block count only when mode bit 5 (multi-block) and mode bit 1 (count enable) are both set; otherwise it is 1. If the word total is zero, completion is raised at once and no word moves.
- R4: With mode bit 4 = 1, the engine writes memory (`mem_we` = 1) with `buf_in_data`. With mode bit 4 = 0, it reads memory (`mem_we` = 0) and forwards `mem_rdata` on `buf_out_data`, with `buf_out_valid` high in each accepting cycle.
- R5: Block config bits [14:12] hold a boundary code c, and the boundary is 4096 << c bytes. When an accepted word leaves the address on a boundary and words remain, `mem_valid` stays 0 and event bit 3 is raised.
- R6: While halted, a write to the system address register resumes the transfer at the written address.
- R7: After the final word, event bit 1 is raised. A final word that lands on a boundary raises bit 1 only.
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A recorded bit stays set until it is cleared.
- R9: An event sets its status bit only if the matching status-enable bit is set.
- R10: `irq` is high exactly when some status bit and its signal-enable bit are both set.
- R11: A transfer-mode write while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| int_status | output | 16 | Recorded interrupt status |
| irq | output | 1 | Interrupt request |
| mem_valid | output | 1 | Memory word request valid |
| mem_ready | input | 1 | Memory accepts the word |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| buf_in_valid | input | 1 | Card buffer offers a word |
| buf_in_ready | output | 1 | Engine takes the offered word |
| buf_in_data | input | 32 | Word from the card buffer |
| buf_out_valid | output | 1 | Word presented to the card buffer |
| buf_out_ready | input | 1 | Card buffer can take a word |
| buf_out_data | output | 32 | Word to the card buffer |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 12-bit block size, a 16-bit count and a 3-bit boundary code. Start addresses are placed a few words below 4 KiB and 8 KiB multiples, so halts, resumes and a completion that lands exactly on a boundary all occur within a handful of words. Each stall pattern on the memory and card-buffer handshakes is a distinct residue of the cycle count, which interleaves back-pressure with every event.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    RG_SADDR  = 3'd0,
    RG_BLKCFG = 3'd1,
    RG_BLKCNT = 3'd2,
    RG_MODE   = 3'd3,
    RG_HCTL   = 3'd4,
    RG_ISTAT  = 3'd5,
    RG_IEN    = 3'd6,
    RG_ISIG   = 3'd7
  } reg_sel_e;

  localparam int MD_DMA   = 0;
  localparam int MD_CNT   = 1;
  localparam int MD_DIR   = 4;
  localparam int MD_MULTI = 5;
  localparam int HC_DSEL  = 3;
  localparam int ST_DONE  = 1;
  localparam int ST_BOUND = 3;
  localparam int BASE_SH  = 12;
endpackage

// File: rtl/sdma_cfg.sv
module sdma_cfg #(
  parameter int AW     = 32,
  parameter int BSZ_W  = 12,
  parameter int BND_W  = 3,
  parameter int BCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_blkcfg,
  input  logic              wr_blkcnt,
  input  logic              wr_hctl,
  input  logic [AW-1:0]     wdata,
  output logic [AW-1:0]     saddr,
  output logic [BSZ_W-1:0]  bsz,
  output logic [BND_W-1:0]  bnd,
  output logic [BCNT_W-1:0] bcnt,
  output logic [1:0]        dsel
);
  import sdma_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      saddr <= '0;
      bsz   <= '0;
      bnd   <= '0;
      bcnt  <= '0;
      dsel  <= '0;
    end else begin
      if (wr_addr)   saddr <= wdata;
      if (wr_blkcfg) begin
        bsz <= wdata[BSZ_W-1:0];
        bnd <= wdata[BSZ_W+BND_W-1:BSZ_W];
      end
      if (wr_blkcnt) bcnt <= wdata[BCNT_W-1:0];
      if (wr_hctl)   dsel <= wdata[HC_DSEL+1:HC_DSEL];
    end
  end
endmodule

// File: rtl/sdma_xfer.sv
module sdma_xfer #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int BSZ_W  = 12,
  parameter int BND_W  = 3,
  parameter int BCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              md_dma,
  input  logic              md_cnt,
  input  logic              md_dir,
  input  logic              md_multi,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [BSZ_W-1:0]  cfg_bsz,
  input  logic [BND_W-1:0]  cfg_bnd,
  input  logic [BCNT_W-1:0] cfg_bcnt,
  input  logic [1:0]        cfg_dsel,
  input  logic              addr_wr,
  input  logic [AW-1:0]     addr_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              buf_in_valid,
  output logic              buf_in_ready,
  input  logic [DW-1:0]     buf_in_data,
  output logic              buf_out_valid,
  input  logic              buf_out_ready,
  output logic [DW-1:0]     buf_out_data,
  output logic              ev_done,
  output logic              ev_bound
);
  import sdma_pkg::*;

  localparam int WPB_W = BSZ_W - 2;

  logic              busy_q, paused_q, dir_q;
  logic [AW-1:0]     addr_q;
  logic [WPB_W-1:0]  wpb_q, wleft_q;
  logic [BCNT_W-1:0] bleft_q;
  logic [BND_W-1:0]  bnd_q;

  logic [WPB_W-1:0]  wpb_w;
  logic [BCNT_W-1:0] blocks_w;
  logic              start_ok, zero_w, active, accept, last_w, cross_w;
  logic [AW-1:0]     addr_inc, bnd_mask;

  assign wpb_w    = cfg_bsz[BSZ_W-1:2];
  assign blocks_w = (md_multi && md_cnt) ? cfg_bcnt : BCNT_W'(1);
  assign start_ok = start_wr && md_dma && (cfg_dsel == 2'b00) && !busy_q;
  assign zero_w   = (wpb_w == '0) || (blocks_w == '0);

  assign active       = busy_q && !paused_q;
  assign mem_valid    = active && (dir_q ? buf_in_valid : buf_out_ready);
  assign buf_in_ready = active && dir_q && mem_ready;
  assign accept       = mem_valid && mem_ready;
  assign mem_we       = dir_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = buf_in_data;
  assign buf_out_valid = accept && !dir_q;
  assign buf_out_data  = mem_rdata;

  assign last_w   = (wleft_q == WPB_W'(1)) && (bleft_q == BCNT_W'(1));
  assign addr_inc = addr_q + AW'(4);
  assign bnd_mask = (AW'(1) << (BASE_SH + int'(bnd_q))) - AW'(1);
  assign cross_w  = (addr_inc & bnd_mask) == '0;

  assign ev_done  = (start_ok && zero_w) || (accept && last_w);
  assign ev_bound = accept && !last_w && cross_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      paused_q <= 1'b0;
      dir_q    <= 1'b0;
      addr_q   <= '0;
      wpb_q    <= '0;
      wleft_q  <= '0;
      bleft_q  <= '0;
      bnd_q    <= '0;
    end else if (start_ok) begin
      busy_q   <= !zero_w;
      paused_q <= 1'b0;
      dir_q    <= md_dir;
      addr_q   <= {cfg_addr[AW-1:2], 2'b00};
      wpb_q    <= wpb_w;
      wleft_q  <= wpb_w;
      bleft_q  <= blocks_w;
      bnd_q    <= cfg_bnd;
    end else if (busy_q) begin
      if (paused_q && addr_wr) begin
        addr_q   <= {addr_wdata[AW-1:2], 2'b00};
        paused_q <= 1'b0;
      end else if (accept) begin
        addr_q <= addr_inc;
        if (last_w) begin
          busy_q <= 1'b0;
        end else begin
          if (wleft_q == WPB_W'(1)) begin
            wleft_q <= wpb_q;
            bleft_q <= bleft_q - BCNT_W'(1);
          end else begin
            wleft_q <= wleft_q - WPB_W'(1);
          end
          if (cross_w) paused_q <= 1'b1;
        end
      end
    end
  end

  // R2: each accepted word moves the address on by one word
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_addr == $past(mem_addr) + AW'(4));
  // R5: after a boundary event the port stays quiet
  p_pause_r5: assert property (@(posedge clk) disable iff (rst)
    ev_bound |=> !mem_valid);
  // R6: resume lands on the address software wrote
  p_resume_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && paused_q && addr_wr) |=> mem_addr == {$past(addr_wdata[AW-1:2]), 2'b00});
  // R7: completion and boundary never fire together
  p_single_r7: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> !ev_bound);
endmodule

// File: rtl/sdma_irq.sv
module sdma_irq #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stat,
  input  logic          wr_en,
  input  logic          wr_sig,
  input  logic [IW-1:0] wdata,
  input  logic [IW-1:0] ev,
  output logic [IW-1:0] status,
  output logic          irq
);
  logic [IW-1:0] stat_q, en_q, sig_q, stat_nxt, sig_nxt;

  for (genvar k = 0; k < IW; k++) begin : g_bit
    assign stat_nxt[k] = (stat_q[k] && !(wr_stat && wdata[k])) || (ev[k] && en_q[k]);
  end
  assign sig_nxt = wr_sig ? wdata : sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      sig_q  <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      sig_q  <= sig_nxt;
      if (wr_en) en_q <= wdata;
      irq    <= |(stat_nxt & sig_nxt);
    end
  end
  assign status = stat_q;

  // R8: a bit written as 1 with no new event is clear afterwards
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[1] && !ev[1]) |=> !stat_q[1]);
  // R8: a recorded bit holds while nothing clears it
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_q[3] && !(wr_stat && wdata[3])) |=> stat_q[3]);
  // R9: a masked-off event cannot set its bit
  p_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_q[3] && !stat_q[3]) |=> !stat_q[3]);
  // R10: interrupt line agrees with the recorded and signal-enabled bits
  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & sig_q));
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int BSZ_W  = 12,
  parameter int BND_W  = 3,
  parameter int BCNT_W = 16,
  parameter int IW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [IW-1:0] int_status,
  output logic          irq,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          buf_in_valid,
  output logic          buf_in_ready,
  input  logic [DW-1:0] buf_in_data,
  output logic          buf_out_valid,
  input  logic          buf_out_ready,
  output logic [DW-1:0] buf_out_data
);
  import sdma_pkg::*;

  logic              wr_addr, wr_blkcfg, wr_blkcnt, wr_mode, wr_hctl;
  logic              wr_stat, wr_en, wr_sig;
  logic [AW-1:0]     c_saddr;
  logic [BSZ_W-1:0]  c_bsz;
  logic [BND_W-1:0]  c_bnd;
  logic [BCNT_W-1:0] c_bcnt;
  logic [1:0]        c_dsel;
  logic              ev_done, ev_bound;
  logic [IW-1:0]     ev_vec;

  assign wr_addr   = reg_wr && (reg_sel == RG_SADDR);
  assign wr_blkcfg = reg_wr && (reg_sel == RG_BLKCFG);
  assign wr_blkcnt = reg_wr && (reg_sel == RG_BLKCNT);
  assign wr_mode   = reg_wr && (reg_sel == RG_MODE);
  assign wr_hctl   = reg_wr && (reg_sel == RG_HCTL);
  assign wr_stat   = reg_wr && (reg_sel == RG_ISTAT);
  assign wr_en     = reg_wr && (reg_sel == RG_IEN);
  assign wr_sig    = reg_wr && (reg_sel == RG_ISIG);

  always_comb begin
    ev_vec           = '0;
    ev_vec[ST_DONE]  = ev_done;
    ev_vec[ST_BOUND] = ev_bound;
  end

  sdma_cfg #(.AW(AW), .BSZ_W(BSZ_W), .BND_W(BND_W), .BCNT_W(BCNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_addr(wr_addr), .wr_blkcfg(wr_blkcfg), .wr_blkcnt(wr_blkcnt), .wr_hctl(wr_hctl),
    .wdata(reg_wdata),
    .saddr(c_saddr), .bsz(c_bsz), .bnd(c_bnd), .bcnt(c_bcnt), .dsel(c_dsel)
  );

  sdma_xfer #(.AW(AW), .DW(DW), .BSZ_W(BSZ_W), .BND_W(BND_W), .BCNT_W(BCNT_W)) u_xfer (
    .clk(clk), .rst(rst),
    .start_wr(wr_mode),
    .md_dma(reg_wdata[MD_DMA]), .md_cnt(reg_wdata[MD_CNT]),
    .md_dir(reg_wdata[MD_DIR]), .md_multi(reg_wdata[MD_MULTI]),
    .cfg_addr(c_saddr), .cfg_bsz(c_bsz), .cfg_bnd(c_bnd), .cfg_bcnt(c_bcnt), .cfg_dsel(c_dsel),
    .addr_wr(wr_addr), .addr_wdata(reg_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_in_valid(buf_in_valid), .buf_in_ready(buf_in_ready), .buf_in_data(buf_in_data),
    .buf_out_valid(buf_out_valid), .buf_out_ready(buf_out_ready), .buf_out_data(buf_out_data),
    .ev_done(ev_done), .ev_bound(ev_bound)
  );

  sdma_irq #(.IW(IW)) u_irq (
    .clk(clk), .rst(rst),
    .wr_stat(wr_stat), .wr_en(wr_en), .wr_sig(wr_sig),
    .wdata(reg_wdata[IW-1:0]), .ev(ev_vec),
    .status(int_status), .irq(irq)
  );
endmodule

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] int_status;
  logic        irq, mem_valid, mem_we, buf_in_ready, buf_out_valid;
  logic        mem_ready = 1'b0, buf_in_valid = 1'b0, buf_out_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, buf_out_data;
  logic [31:0] buf_in_data = '0;

  int checks = 0, failures = 0, cyc = 0, wc = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

  sdma_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .int_status(int_status), .irq(irq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_in_valid(buf_in_valid), .buf_in_ready(buf_in_ready), .buf_in_data(buf_in_data),
    .buf_out_valid(buf_out_valid), .buf_out_ready(buf_out_ready), .buf_out_data(buf_out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stimulus patterns for the handshakes
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    mem_ready     = (cyc % 5) != 2;
    buf_in_valid  = (cyc % 3) != 0;
    buf_out_ready = (cyc % 4) != 3;
    buf_in_data   = 32'hD000_0000 + cyc;
  end

  // behavioural reference model
  bit          m_busy, m_paused, m_dir, m_irq;
  logic [31:0] m_addr, m_saddr;
  int          m_left, m_bsz, m_bnd, m_cnt, m_dsel, m_cur_bnd;
  logic [15:0] m_stat, m_en, m_sig;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_paused = 0; m_dir = 0; m_irq = 0; m_addr = 0; m_saddr = 0;
      m_left = 0; m_bsz = 0; m_bnd = 0; m_cnt = 0; m_dsel = 0; m_cur_bnd = 0;
      m_stat = 0; m_en = 0; m_sig = 0;
    end else begin
      bit acc, was_busy, was_paused;
      logic [15:0] ev, clr, en_old;
      was_busy = m_busy; was_paused = m_paused;
      acc = m_busy && !m_paused && (m_dir ? buf_in_valid : buf_out_ready) && mem_ready;
      ev = 0; clr = 0; en_old = m_en;
      if (reg_wr) begin
        case (reg_sel)
          3'd0: begin
            m_saddr = reg_wdata;
            if (was_busy && was_paused) begin m_addr = reg_wdata & ~32'd3; m_paused = 0; end
          end
          3'd1: begin m_bsz = reg_wdata[11:0]; m_bnd = reg_wdata[14:12]; end
          3'd2: m_cnt = reg_wdata[15:0];
          3'd3: if (reg_wdata[0] && m_dsel == 0 && !was_busy) begin
            int tot;
            tot = ((reg_wdata[5] && reg_wdata[1]) ? m_cnt : 1) * (m_bsz / 4);
            if (tot == 0) ev[1] = 1;
            else begin
              m_busy = 1; m_paused = 0; m_addr = m_saddr & ~32'd3; m_left = tot;
              m_dir = reg_wdata[4]; m_cur_bnd = m_bnd;
            end
          end
          3'd4: m_dsel = reg_wdata[4:3];
          3'd5: clr = reg_wdata[15:0];
          3'd6: m_en = reg_wdata[15:0];
          default: m_sig = reg_wdata[15:0];
        endcase
      end
      if (acc) begin
        m_left = m_left - 1;
        m_addr = m_addr + 4;
        if (m_left == 0) begin m_busy = 0; ev[1] = 1; end
        else if ((m_addr % (32'h1000 << m_cur_bnd)) == 0) begin m_paused = 1; ev[3] = 1; end
      end
      m_stat = (m_stat & ~clr) | (ev & en_old);
      m_irq = |(m_stat & m_sig);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      bit act, e_mv;
      act  = m_busy && !m_paused;
      e_mv = act && (m_dir ? buf_in_valid : buf_out_ready);
      checks++;
      if (mem_valid !== e_mv) begin failures++; $display("FAIL R2 mem_valid actual=%h expected=%h", mem_valid, e_mv); end
      if (e_mv && mem_addr !== m_addr) begin failures++; $display("FAIL R2 mem_addr actual=%h expected=%h", mem_addr, m_addr); end
      if (e_mv && mem_we !== m_dir) begin failures++; $display("FAIL R4 mem_we actual=%h expected=%h", mem_we, m_dir); end
      if (e_mv && m_dir && mem_wdata !== buf_in_data) begin failures++; $display("FAIL R4 mem_wdata actual=%h expected=%h", mem_wdata, buf_in_data); end
      if (buf_in_ready !== (act && m_dir && mem_ready)) begin failures++; $display("FAIL R4 buf_in_ready actual=%h expected=%h", buf_in_ready, act && m_dir && mem_ready); end
      if (buf_out_valid !== (e_mv && mem_ready && !m_dir)) begin failures++; $display("FAIL R4 buf_out_valid actual=%h expected=%h", buf_out_valid, e_mv && mem_ready && !m_dir); end
      if (buf_out_valid && buf_out_data !== (m_addr ^ 32'h5A5A_0000)) begin failures++; $display("FAIL R4 buf_out_data actual=%h expected=%h", buf_out_data, m_addr ^ 32'h5A5A_0000); end
      if (int_status !== m_stat) begin failures++; $display("FAIL R9 int_status actual=%h expected=%h", int_status, m_stat); end
      if (irq !== m_irq) begin failures++; $display("FAIL R10 irq actual=%h expected=%h", irq, m_irq); end
      if (mem_valid && mem_ready) wc++;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic wait_stat(input logic [15:0] m);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ((int_status & m) != 0) break;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(int_status == 0 && irq == 0 && mem_valid == 0 && buf_out_valid == 0, "R1 reset outputs",
        {int_status, 13'b0, irq, mem_valid, buf_out_valid}, 32'd0);

    wr(3'd6, 32'h000A);
    wr(3'd7, 32'h000A);

    // write to card, 3 blocks of 4 words
    wr(3'd0, 32'h1000_0100); wr(3'd1, 32'h0000_0010); wr(3'd2, 32'd3);
    wc = 0;
    wr(3'd3, 32'h0000_0023);
    wait_stat(16'h0002);
    chk(wc == 12, "R3 multi-block word total", wc, 12);
    chk(int_status == 16'h0002, "R7 completion bit", int_status, 16'h0002);
    settle(1);
    chk(irq == 1, "R10 irq with done enabled", irq, 1);
    wr(3'd5, 32'h0000_0008);
    settle(1);
    chk(int_status == 16'h0002, "R8 write of 0 keeps bit", int_status, 16'h0002);
    wr(3'd5, 32'h0000_0002);
    settle(1);
    chk(int_status == 0 && irq == 0, "R8 write 1 clears", int_status, 0);

    // read from card across a 4 KiB boundary, then resume elsewhere
    wr(3'd0, 32'h0000_0FF8); wr(3'd1, 32'h0000_0020);
    wc = 0;
    wr(3'd3, 32'h0000_0011);
    wait_stat(16'h0008);
    chk(int_status == 16'h0008 && wc == 2, "R5 halt at boundary", {int_status, wc[15:0]}, {16'h0008, 16'd2});
    begin
      bit quiet = 1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_valid) quiet = 0; end
      chk(quiet, "R5 no request while halted", quiet, 1);
    end
    wr(3'd5, 32'h0000_0008);
    wr(3'd0, 32'h2000_0000);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_valid) break; end
    chk(mem_addr == 32'h2000_0000 && mem_we == 1, "R6 resume address", mem_addr, 32'h2000_0000);
    wait_stat(16'h0002);
    chk(wc == 8 && int_status == 16'h0002, "R7 done after resume", wc, 8);
    wr(3'd5, 32'h0000_FFFF);

    // 8 KiB boundary: 0x1000 not a halt point, 0x2000 is
    wr(3'd0, 32'h0000_0FF0); wr(3'd1, 32'h0000_1020);
    wc = 0;
    wr(3'd3, 32'h0000_0001);
    wait_stat(16'h000A);
    chk(int_status == 16'h0002 && wc == 8, "R5 code 1 passes 4 KiB", int_status, 16'h0002);
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd0, 32'h0000_1FF0);
    wc = 0;
    wr(3'd3, 32'h0000_0001);
    wait_stat(16'h000A);
    chk(int_status == 16'h0008 && wc == 4, "R5 code 1 halts at 8 KiB", int_status, 16'h0008);
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd0, 32'h0000_4000);
    wait_stat(16'h0002);
    chk(wc == 8, "R6 resumed words", wc, 8);
    wr(3'd5, 32'h0000_FFFF);

    // final word lands on a boundary: completion only
    wr(3'd0, 32'h0000_3FF0); wr(3'd1, 32'h0000_0010);
    wr(3'd3, 32'h0000_0001);
    wait_stat(16'h000A);
    settle(3);
    chk(int_status == 16'h0002, "R7 boundary on last word", int_status, 16'h0002);
    wr(3'd5, 32'h0000_FFFF);

    // multi-block without count enable moves one block
    wr(3'd0, 32'h0000_5000); wr(3'd1, 32'h0000_0008); wr(3'd2, 32'd5);
    wc = 0;
    wr(3'd3, 32'h0000_0021);
    wait_stat(16'h0002);
    settle(3);
    chk(wc == 2, "R3 count ignored without enable", wc, 2);
    wr(3'd5, 32'h0000_FFFF);

    // nonzero DMA select: nothing starts
    wr(3'd4, 32'h0000_0010);
    wc = 0;
    wr(3'd3, 32'h0000_0001);
    settle(20);
    chk(wc == 0 && int_status == 0, "R2 select 10 blocks start", wc, 0);
    wr(3'd4, 32'h0000_0000);
    // DMA enable clear: nothing starts
    wr(3'd3, 32'h0000_0000);
    settle(20);
    chk(wc == 0 && int_status == 0, "R2 enable clear blocks start", wc, 0);

    // zero block count with count enable: immediate completion
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h0000_0023);
    settle(1);
    chk(int_status == 16'h0002 && wc == 0, "R3 zero count completes", int_status, 16'h0002);
    wr(3'd5, 32'h0000_FFFF);

    // mode write while busy is ignored
    wr(3'd0, 32'h0000_6000); wr(3'd1, 32'h0000_0010); wr(3'd2, 32'd4);
    wc = 0;
    wr(3'd3, 32'h0000_0023);
    settle(3);
    wr(3'd3, 32'h0000_0011);
    wait_stat(16'h0002);
    settle(5);
    chk(wc == 16 && int_status == 16'h0002, "R11 busy mode write ignored", wc, 16);
    wr(3'd5, 32'h0000_FFFF);

    // status enable gating and signal enable
    wr(3'd6, 32'h0000_0002);
    wr(3'd7, 32'h0000_0008);
    wr(3'd0, 32'h0000_7FF8); wr(3'd1, 32'h0000_0010);
    wc = 0;
    wr(3'd3, 32'h0000_0001);
    settle(40);
    chk(int_status == 0 && wc == 2 && mem_valid == 0, "R9 masked boundary event", int_status, 0);
    wr(3'd0, 32'h0000_9000);
    wait_stat(16'h0002);
    settle(1);
    chk(int_status == 16'h0002 && irq == 0, "R10 irq off without signal enable", irq, 0);
    wr(3'd7, 32'h0000_0002);
    settle(1);
    chk(irq == 1, "R10 irq on with signal enable", irq, 1);

    settle(2);
    finish_run();
  end
endmodule